// File: doc/BRIEF.md
# Operand Bypass Select and Load-Use Stall

This block is the hazard controller for a five-stage pipeline in which every result can be forwarded. Each cycle it compares the two source registers of the instruction in decode with the destination registers of the instructions now in execute, memory and writeback. From that comparison it produces one select code per ALU operand. The code tells the datapath multiplexers whether to take the operand from the register file or from the result held in one of the three later stages.

A result is forwardable only once it exists. An arithmetic result, and by default a link address, exists at the end of execute. Load data exists only after the memory stage. When the youngest producer of a needed register is a load still in execute, the block raises `stall`, and the decode stage must then hold its instruction for a cycle. Register 0 is hard-wired to zero, so it never produces a match. A write-enable is honoured only for operation classes that write a register.

The block is purely combinational and has no clock. Every pin is a plain control signal, so no stream handshake applies.

Top module: `hzd_bypass_ctrl`

Operation class encoding on the `*_opc` pins: 0 register-register arithmetic, 1 register-immediate arithmetic, 2 load, 3 store, 4 conditional branch, 5 plain jump, 6 jump-and-link (either form), 7 empty slot.

## Requirements
- R1: `sel_a` is 1 (execute) when `dec_rs_en` is set, `dec_rs` is nonzero and equals `ex_dst`, `ex_wen` is set, and `ex_opc` is class 0 or 1.
- R2: `sel_a` is 2 (memory) when the memory stage is the youngest matching producer, for any writing class including a load (class 2).
- R3: `sel_a` is 3 (writeback) when the writeback stage is the only matching producer. Code 0 means the register file.
- R4: When more than one stage matches, the youngest wins: execute over memory, and memory over writeback.
- R5: A source register of 0 yields select 0 and never raises `stall`, even when a later stage names destination 0 with its write-enable set.
- R6: With its read-enable low, an operand's select is 0 and that operand cannot cause a stall. With every input idle, both selects are 0 and `stall` is 0.
- R7: `sel_b` obeys the same rules as `sel_a`, using `dec_rt` and `dec_rt_en`. The two operands are independent.
- R8: `stall` is 1 exactly when execute holds a load (class 2) with `ex_wen` set and a nonzero `ex_dst` that equals a decode source whose read-enable is set.
- R9: Store, branch and plain jump (classes 3, 4, 5) are never producers, whatever their write-enable or destination.
- R10: With `LINK_FWD_E` = 1 (the default), a jump-and-link in execute is forwarded with select 1 and no stall. With 0, it stalls like a load.
- R11: When the youngest match for an operand is a result not yet available, that operand's select is 0, even if an older stage also matches.
- R12: When a dependent instruction stream is run through a pipeline that uses the selects and the stall, every forwarded operand value equals the value a sequential register model gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | REG_W | First source register of the decode instruction |
| dec_rt | input | REG_W | Second source register of the decode instruction |
| dec_rs_en | input | 1 | Decode reads its first source |
| dec_rt_en | input | 1 | Decode reads its second source |
| ex_opc | input | 3 | Operation class in execute |
| ex_dst | input | REG_W | Destination register in execute |
| ex_wen | input | 1 | Write-enable in execute |
| mem_opc | input | 3 | Operation class in memory |
| mem_dst | input | REG_W | Destination register in memory |
| mem_wen | input | 1 | Write-enable in memory |
| wb_opc | input | 3 | Operation class in writeback |
| wb_dst | input | REG_W | Destination register in writeback |
| wb_wen | input | 1 | Write-enable in writeback |
| sel_a | output | 2 | Operand A source: 0 register file, 1 execute, 2 memory, 3 writeback |
| sel_b | output | 2 | Operand B source, same coding |
| stall | output | 1 | Hold decode for one cycle |

## Verification
The assertions check each output against the input ports seen at the same moment. They assume no relation between a stage's opcode class and its write-enable, because the block must ignore write-enables that come with non-writing classes. The stimulus therefore drives a set write-enable with store, branch and jump classes, and with destination 0. In the pipeline model, every occupied later stage carries its write-enable high regardless of class, so the qualification is exercised during ordinary runs.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [2:0] {
    OPC_ALU   = 3'd0,
    OPC_ALUI  = 3'd1,
    OPC_LOAD  = 3'd2,
    OPC_STORE = 3'd3,
    OPC_BRZ   = 3'd4,
    OPC_JUMP  = 3'd5,
    OPC_LINK  = 3'd6,
    OPC_NOP   = 3'd7
  } opc_t;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } src_t;

  // later stages scanned: execute, memory, writeback (youngest first)
  localparam int unsigned N_LATER = 3;
  localparam int unsigned SEL_W   = $clog2(N_LATER + 1);

  function automatic logic opc_writes(opc_t op);
    return (op == OPC_ALU) || (op == OPC_ALUI) || (op == OPC_LOAD) || (op == OPC_LINK);
  endfunction
endpackage

// File: rtl/hzd_producer.sv
module hzd_producer
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W      = 5,
  parameter int unsigned STG        = 0,
  parameter bit          LINK_FWD_E = 1'b1
) (
  input  logic [2:0]       opc,
  input  logic [REG_W-1:0] dst,
  input  logic             wen,
  output logic             live,
  output logic             ready
);
  opc_t op;
  logic early;

  assign op   = opc_t'(opc);
  assign live = wen && (dst != '0) && opc_writes(op);

  generate
    if (STG == 0) begin : g_ex
      if (LINK_FWD_E) begin : g_link_fwd
        assign early = (op == OPC_ALU) || (op == OPC_ALUI) || (op == OPC_LINK);
      end else begin : g_link_stall
        assign early = (op == OPC_ALU) || (op == OPC_ALUI);
      end
    end else begin : g_late
      assign early = 1'b1;
    end
  endgenerate

  assign ready = live && early;
endmodule

// File: rtl/hzd_operand_sel.sv
module hzd_operand_sel
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0]         src,
  input  logic                     rd_en,
  input  logic [N_LATER-1:0]       live,
  input  logic [N_LATER-1:0]       ready,
  input  logic [N_LATER*REG_W-1:0] dst_flat,
  output logic [SEL_W-1:0]         sel,
  output logic                     block
);
  logic [N_LATER-1:0] hit;

  generate
    for (genvar g = 0; g < N_LATER; g++) begin : g_cmp
      assign hit[g] = rd_en && (src != '0) && live[g] &&
                      (dst_flat[g*REG_W +: REG_W] == src);
    end
  endgenerate

  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    block = 1'b0;
    for (int k = 0; k < N_LATER; k++) begin
      if (!found && hit[k]) begin
        found = 1'b1;
        if (ready[k]) sel = SEL_W'(k + 1);
        else          block = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hzd_bypass_ctrl.sv
module hzd_bypass_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W      = 5,
  parameter bit          LINK_FWD_E = 1'b1
) (
  input  logic [REG_W-1:0] dec_rs,
  input  logic [REG_W-1:0] dec_rt,
  input  logic             dec_rs_en,
  input  logic             dec_rt_en,
  input  logic [2:0]       ex_opc,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic [2:0]       mem_opc,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic [2:0]       wb_opc,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             stall
);
  logic [2:0]               opc_v [N_LATER];
  logic [REG_W-1:0]         dst_v [N_LATER];
  logic [N_LATER-1:0]       wen_v;
  logic [N_LATER-1:0]       live, ready;
  logic [N_LATER*REG_W-1:0] dst_flat;
  logic                     block_a, block_b;

  assign opc_v[0] = ex_opc;  assign dst_v[0] = ex_dst;  assign wen_v[0] = ex_wen;
  assign opc_v[1] = mem_opc; assign dst_v[1] = mem_dst; assign wen_v[1] = mem_wen;
  assign opc_v[2] = wb_opc;  assign dst_v[2] = wb_dst;  assign wen_v[2] = wb_wen;

  generate
    for (genvar s = 0; s < N_LATER; s++) begin : g_stage
      hzd_producer #(.REG_W(REG_W), .STG(s), .LINK_FWD_E(LINK_FWD_E)) u_prod (
        .opc   (opc_v[s]),
        .dst   (dst_v[s]),
        .wen   (wen_v[s]),
        .live  (live[s]),
        .ready (ready[s])
      );
      assign dst_flat[s*REG_W +: REG_W] = dst_v[s];
    end
  endgenerate

  hzd_operand_sel #(.REG_W(REG_W)) u_sel_a (
    .src (dec_rs), .rd_en (dec_rs_en), .live (live), .ready (ready),
    .dst_flat (dst_flat), .sel (sel_a), .block (block_a)
  );

  hzd_operand_sel #(.REG_W(REG_W)) u_sel_b (
    .src (dec_rt), .rd_en (dec_rt_en), .live (live), .ready (ready),
    .dst_flat (dst_flat), .sel (sel_b), .block (block_b)
  );

  assign stall = block_a || block_b;
endmodule

// File: rtl/hzd_bypass_ctrl_chk.sv
module hzd_bypass_ctrl_chk
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W      = 5,
  parameter bit          LINK_FWD_E = 1'b1
) (
  input logic [REG_W-1:0] dec_rs,
  input logic [REG_W-1:0] dec_rt,
  input logic             dec_rs_en,
  input logic             dec_rt_en,
  input logic [2:0]       ex_opc,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_wen,
  input logic [2:0]       mem_opc,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wen,
  input logic [2:0]       wb_opc,
  input logic [REG_W-1:0] wb_dst,
  input logic             wb_wen,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic             stall
);
  logic ex_prod, mem_prod, wb_prod, ex_late;

  assign ex_prod  = ex_wen  && (ex_dst  != '0) && opc_writes(opc_t'(ex_opc));
  assign mem_prod = mem_wen && (mem_dst != '0) && opc_writes(opc_t'(mem_opc));
  assign wb_prod  = wb_wen  && (wb_dst  != '0) && opc_writes(opc_t'(wb_opc));
  assign ex_late  = (opc_t'(ex_opc) == OPC_LOAD) ||
                    (!LINK_FWD_E && (opc_t'(ex_opc) == OPC_LINK));

  always_comb begin
    // R5
    if (dec_rs == '0)
      zero_a_chk: assert (sel_a == SRC_RF) else $error("zero source forwarded on A");
    // R6
    if (!dec_rt_en)
      ren_b_chk: assert (sel_b == SRC_RF) else $error("unread B operand forwarded");
    // R1
    if (sel_a == SRC_EX)
      ex_src_chk: assert (dec_rs_en && ex_prod && !ex_late && (dec_rs == ex_dst))
        else $error("execute select without producer");
    // R4
    if (sel_a == SRC_MEM)
      mem_prio_chk: assert (mem_prod && (dec_rs == mem_dst) && !(ex_prod && (ex_dst == dec_rs)))
        else $error("memory select with younger match or no producer");
    // R3
    if (sel_a == SRC_WB)
      wb_src_chk: assert (wb_prod && (dec_rs == wb_dst) && !(mem_prod && (mem_dst == dec_rs)))
        else $error("writeback select with younger match or no producer");
    // R8
    if (stall)
      stall_cause_chk: assert (ex_prod && ex_late &&
                               ((dec_rs_en && dec_rs == ex_dst) || (dec_rt_en && dec_rt == ex_dst)))
        else $error("stall without late producer in execute");
    // R11
    if (stall && dec_rt_en && (dec_rt == ex_dst))
      stall_sel_chk: assert (sel_b == SRC_RF) else $error("B forwarded while its producer is late");
  end
endmodule

bind hzd_bypass_ctrl hzd_bypass_ctrl_chk #(.REG_W(REG_W), .LINK_FWD_E(LINK_FWD_E)) u_chk (.*);

// File: tb/hzd_bypass_ctrl_bench.sv
module hzd_bypass_ctrl_bench;
  import hzd_pkg::*;
  localparam int REG_W = 5;
  localparam int PMAX  = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n;

  logic [REG_W-1:0] dec_rs, dec_rt, ex_dst, mem_dst, wb_dst;
  logic dec_rs_en, dec_rt_en, ex_wen, mem_wen, wb_wen;
  logic [2:0] ex_opc, mem_opc, wb_opc;
  logic [1:0] sel_a, sel_b;
  logic stall;

  hzd_bypass_ctrl #(.REG_W(REG_W), .LINK_FWD_E(1'b1)) u_hzd_bypass_ctrl (
    .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_rs_en(dec_rs_en), .dec_rt_en(dec_rt_en),
    .ex_opc(ex_opc), .ex_dst(ex_dst), .ex_wen(ex_wen),
    .mem_opc(mem_opc), .mem_dst(mem_dst), .mem_wen(mem_wen),
    .wb_opc(wb_opc), .wb_dst(wb_dst), .wb_wen(wb_wen),
    .sel_a(sel_a), .sel_b(sel_b), .stall(stall)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle_in;
    dec_rs = '0; dec_rt = '0; dec_rs_en = 1'b0; dec_rt_en = 1'b0;
    ex_opc = OPC_NOP;  ex_dst = '0;  ex_wen = 1'b0;
    mem_opc = OPC_NOP; mem_dst = '0; mem_wen = 1'b0;
    wb_opc = OPC_NOP;  wb_dst = '0;  wb_wen = 1'b0;
  endtask

  // ---------------- directed scenarios ----------------
  task automatic t_idle;
    @(negedge clk); idle_in; #1;
    chk("R6 idle sel_a", sel_a, 0); chk("R6 idle sel_b", sel_b, 0); chk("R6 idle stall", stall, 0);
  endtask

  task automatic t_ex;
    @(negedge clk); idle_in;
    dec_rs = 3; dec_rs_en = 1; ex_opc = OPC_ALU; ex_dst = 3; ex_wen = 1; #1;
    chk("R1 alu in ex", sel_a, 1); chk("R1 no stall", stall, 0);
    ex_opc = OPC_ALUI; #1;
    chk("R1 alui in ex", sel_a, 1);
  endtask

  task automatic t_mem;
    @(negedge clk); idle_in;
    dec_rs = 4; dec_rs_en = 1; mem_opc = OPC_LOAD; mem_dst = 4; mem_wen = 1; #1;
    chk("R2 load in mem", sel_a, 2); chk("R2 no stall", stall, 0);
  endtask

  task automatic t_wb;
    @(negedge clk); idle_in;
    dec_rs = 6; dec_rs_en = 1; wb_opc = OPC_ALU; wb_dst = 6; wb_wen = 1; #1;
    chk("R3 alu in wb", sel_a, 3);
    wb_wen = 0; #1;
    chk("R3 wb no wen", sel_a, 0);
  endtask

  task automatic t_prio;
    @(negedge clk); idle_in;
    dec_rs = 5; dec_rs_en = 1;
    ex_opc = OPC_ALU; ex_dst = 5; ex_wen = 1;
    mem_opc = OPC_ALU; mem_dst = 5; mem_wen = 1;
    wb_opc = OPC_LOAD; wb_dst = 5; wb_wen = 1; #1;
    chk("R4 ex over mem", sel_a, 1);
    ex_wen = 0; #1;
    chk("R4 mem over wb", sel_a, 2);
  endtask

  task automatic t_zero;
    @(negedge clk); idle_in;
    dec_rs = 0; dec_rs_en = 1; dec_rt = 0; dec_rt_en = 1;
    ex_opc = OPC_ALU; ex_dst = 0; ex_wen = 1; #1;
    chk("R5 r0 alu", sel_a, 0);
    ex_opc = OPC_LOAD; #1;
    chk("R5 r0 load stall", stall, 0); chk("R5 r0 sel_b", sel_b, 0);
  endtask

  task automatic t_reoff;
    @(negedge clk); idle_in;
    dec_rs = 8; dec_rs_en = 0; ex_opc = OPC_LOAD; ex_dst = 8; ex_wen = 1; #1;
    chk("R6 re off stall", stall, 0); chk("R6 re off sel", sel_a, 0);
  endtask

  task automatic t_opb;
    @(negedge clk); idle_in;
    dec_rt = 7; dec_rt_en = 1; dec_rs = 2; dec_rs_en = 1;
    mem_opc = OPC_ALU; mem_dst = 7; mem_wen = 1;
    ex_opc = OPC_ALUI; ex_dst = 2; ex_wen = 1; #1;
    chk("R7 sel_b mem", sel_b, 2); chk("R7 sel_a ex", sel_a, 1);
    ex_opc = OPC_LOAD; #1;
    chk("R7 stall from A", stall, 1); chk("R7 B unaffected", sel_b, 2);
  endtask

  task automatic t_load;
    @(negedge clk); idle_in;
    dec_rs = 9; dec_rs_en = 1; ex_opc = OPC_LOAD; ex_dst = 9; ex_wen = 1;
    mem_opc = OPC_ALU; mem_dst = 9; mem_wen = 1; #1;
    chk("R8 load-use stall", stall, 1); chk("R11 sel held at rf", sel_a, 0);
    ex_dst = 10; #1;
    chk("R8 other dst no stall", stall, 0); chk("R2 older mem used", sel_a, 2);
  endtask

  task automatic t_nonwr;
    @(negedge clk); idle_in;
    dec_rs = 3; dec_rs_en = 1; dec_rt = 3; dec_rt_en = 1;
    ex_opc = OPC_STORE; ex_dst = 3; ex_wen = 1; #1;
    chk("R9 store in ex", sel_a, 0);
    ex_opc = OPC_BRZ; #1;  chk("R9 branch in ex", sel_b, 0);
    ex_opc = OPC_JUMP; #1; chk("R9 jump in ex", sel_a, 0);
    ex_opc = OPC_NOP; mem_opc = OPC_STORE; mem_dst = 3; mem_wen = 1; #1;
    chk("R9 store in mem", sel_a, 0); chk("R9 no stall", stall, 0);
  endtask

  task automatic t_link;
    @(negedge clk); idle_in;
    dec_rs = 31; dec_rs_en = 1; ex_opc = OPC_LINK; ex_dst = 31; ex_wen = 1; #1;
    chk("R10 link forwarded", sel_a, 1); chk("R10 link no stall", stall, 0);
  endtask

  // ---------------- pipeline model ----------------
  int p_op[PMAX], p_rd[PMAX], p_rs[PMAX], p_rt[PMAX], p_re1[PMAX], p_re2[PMAX];
  logic [31:0] p_imm[PMAX], exp_a[PMAX], exp_b[PMAX];
  int p_n;
  logic [31:0] brf[32];
  logic [31:0] rrf[32];
  logic [31:0] ve, vm, vw;

  function automatic logic [31:0] memf(logic [31:0] a);
    return a * 32'd7 + 32'd3;
  endfunction

  function automatic bit writes_op(int op);
    return op == OPC_ALU || op == OPC_ALUI || op == OPC_LOAD || op == OPC_LINK;
  endfunction

  function automatic logic [31:0] result(int i, logic [31:0] a, logic [31:0] b);
    case (p_op[i])
      OPC_ALU:  return a + b;
      OPC_ALUI: return a + p_imm[i];
      OPC_LOAD: return a + p_imm[i];          // address; data appears after memory
      OPC_LINK: return 32'h100 + 32'(i) * 4;
      default:  return 32'h0;
    endcase
  endfunction

  task automatic add_ins(int op, int rd, int rs, int rt, int re1, int re2, logic [31:0] imm);
    p_op[p_n] = op; p_rd[p_n] = rd; p_rs[p_n] = rs; p_rt[p_n] = rt;
    p_re1[p_n] = re1; p_re2[p_n] = re2; p_imm[p_n] = imm; p_n++;
  endtask

  task automatic ref_run;
    for (int r = 0; r < 32; r++) rrf[r] = 32'h0;
    for (int i = 0; i < p_n; i++) begin
      logic [31:0] a, b, v;
      a = rrf[p_rs[i]]; b = rrf[p_rt[i]];
      exp_a[i] = a; exp_b[i] = b;
      v = result(i, a, b);
      if (p_op[i] == OPC_LOAD) v = memf(v);
      if (writes_op(p_op[i]) && p_rd[i] != 0) rrf[p_rd[i]] = v;
    end
  endtask

  function automatic logic [31:0] pick(logic [1:0] s, int r);
    case (s)
      2'd1:    return ve;
      2'd2:    return vm;
      2'd3:    return vw;
      default: return brf[r];
    endcase
  endfunction

  task automatic run_prog(string name);
    int sd, se, sm, sw, nxt, guard;
    logic [31:0] nv;
    logic st, exp_st;
    ref_run;
    for (int r = 0; r < 32; r++) brf[r] = 32'h0;
    sd = 0; nxt = 1; se = -1; sm = -1; sw = -1; guard = 0;
    ve = 0; vm = 0; vw = 0; nv = 0;
    while ((sd >= 0 || se >= 0 || sm >= 0 || sw >= 0) && guard < 200) begin
      guard++;
      @(negedge clk);
      dec_rs    = (sd >= 0) ? REG_W'(p_rs[sd]) : '0;
      dec_rt    = (sd >= 0) ? REG_W'(p_rt[sd]) : '0;
      dec_rs_en = (sd >= 0) && p_re1[sd] != 0;
      dec_rt_en = (sd >= 0) && p_re2[sd] != 0;
      ex_opc  = (se >= 0) ? 3'(p_op[se]) : OPC_NOP; ex_dst  = (se >= 0) ? REG_W'(p_rd[se]) : '0; ex_wen  = se >= 0;
      mem_opc = (sm >= 0) ? 3'(p_op[sm]) : OPC_NOP; mem_dst = (sm >= 0) ? REG_W'(p_rd[sm]) : '0; mem_wen = sm >= 0;
      wb_opc  = (sw >= 0) ? 3'(p_op[sw]) : OPC_NOP; wb_dst  = (sw >= 0) ? REG_W'(p_rd[sw]) : '0; wb_wen  = sw >= 0;
      #1;
      st = stall;
      exp_st = (se >= 0) && (sd >= 0) && p_op[se] == OPC_LOAD && p_rd[se] != 0 &&
               ((p_re1[sd] != 0 && p_rs[sd] == p_rd[se]) || (p_re2[sd] != 0 && p_rt[sd] == p_rd[se]));
      chk({"R8 stall in ", name}, st, exp_st);
      if (sd >= 0 && !st) begin
        logic [31:0] a, b;
        a = pick(sel_a, p_rs[sd]); b = pick(sel_b, p_rt[sd]);
        if (p_re1[sd] != 0) chk($sformatf("R12 %s op A of #%0d", name, sd), a, exp_a[sd]);
        if (p_re2[sd] != 0) chk($sformatf("R12 %s op B of #%0d", name, sd), b, exp_b[sd]);
        nv = result(sd, a, b);
      end
      @(posedge clk);
      if (sw >= 0 && writes_op(p_op[sw]) && p_rd[sw] != 0) brf[p_rd[sw]] = vw;
      sw = sm; vw = vm;
      sm = se; vm = (se >= 0 && p_op[se] == OPC_LOAD) ? memf(ve) : ve;
      if (st) se = -1;
      else begin
        se = sd; ve = nv;
        if (nxt < p_n) begin sd = nxt; nxt++; end
        else sd = -1;
      end
    end
    for (int r = 1; r < 32; r++)
      if (rrf[r] !== brf[r]) chk($sformatf("R12 %s final r%0d", name, r), brf[r], rrf[r]);
    chk({"R12 drained ", name}, (guard < 200), 1);
  endtask

  task automatic t_prog_chain;
    p_n = 0;
    add_ins(OPC_ALUI, 1, 0, 0, 1, 0, 5);
    add_ins(OPC_ALU,  2, 1, 1, 1, 1, 0);
    add_ins(OPC_ALU,  3, 2, 1, 1, 1, 0);
    add_ins(OPC_LOAD, 4, 3, 0, 1, 0, 2);
    add_ins(OPC_ALU,  5, 4, 2, 1, 1, 0);
    add_ins(OPC_STORE,5, 5, 4, 1, 1, 0);
    add_ins(OPC_ALU,  6, 5, 1, 1, 1, 0);
    add_ins(OPC_LINK, 31, 0, 0, 0, 0, 0);
    add_ins(OPC_ALU,  7, 31, 4, 1, 1, 0);
    add_ins(OPC_ALUI, 0, 7, 0, 1, 0, 9);
    add_ins(OPC_ALU,  8, 0, 7, 1, 1, 0);
    run_prog("chain");
  endtask

  task automatic t_prog_loads;
    p_n = 0;
    add_ins(OPC_ALUI, 10, 0, 0, 1, 0, 100);
    add_ins(OPC_ALUI, 11, 0, 0, 1, 0, 1);
    add_ins(OPC_ALUI, 12, 0, 0, 1, 0, 2);
    add_ins(OPC_ALU,  13, 10, 11, 1, 1, 0);
    add_ins(OPC_LOAD, 14, 13, 0, 1, 0, 0);
    add_ins(OPC_ALUI, 15, 0, 0, 1, 0, 7);
    add_ins(OPC_ALU,  16, 14, 14, 1, 1, 0);
    add_ins(OPC_LOAD, 17, 16, 0, 1, 0, 1);
    add_ins(OPC_LOAD, 18, 17, 0, 1, 0, 0);
    add_ins(OPC_ALU,  19, 18, 17, 1, 1, 0);
    run_prog("loads");
  endtask

  initial begin
    rst_n = 1'b0;
    idle_in;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle;
    t_ex;
    t_mem;
    t_wb;
    t_prio;
    t_zero;
    t_reoff;
    t_opb;
    t_load;
    t_nonwr;
    t_link;
    t_prog_chain;
    t_prog_loads;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule